// File: doc/BRIEF.md
# Packet Event Timestamp Capture Queue

This block keeps a short queue of hardware timestamps for timing-protocol event messages. Whenever the packet front end reports a start-of-packet for an event message, it raises a one-cycle strobe. The strobe carries the message's sequence identifier, its 4-bit message type and its direction (transmit or receive). If capture is enabled for that direction, the block stores the current time of day with the metadata as one queue entry. The time of day is 32-bit seconds and 32-bit nanoseconds.

Software drains the queue through a small register interface with 16-bit data. It first writes the read-start bit, which freezes the oldest entry. It then reads the four time slices and the two metadata registers. Writing the read-end bit releases that entry and removes it from the queue, and a final write of zero returns the control register to idle. A pending bit in the status register, also brought out as a level output, stays high while any entry is waiting. A sticky flag records that a capture was lost because the queue was full.

Top module: `ts_capture_queue`

## Requirements
- R1: After reset the queue is empty, `irq_pending` is 0, the control register (address 0) reads 0, the status register (address 2) reads 0, and every entry register (addresses 4 to 9) reads 0 while the queue is empty.
- R2: The control register holds the global sync enable in bit 0, transmit capture enable in bit 1 and receive capture enable in bit 2. An event strobe with `evt_tx`=1 is stored only when bits 0 and 1 are both set. An event with `evt_tx`=0 is stored only when bits 0 and 2 are both set. Any other event is ignored and leaves the queue unchanged.
- R3: A stored timestamp holds `time_sec` and `time_nsec` as sampled on the clock edge that accepts the strobe. Address 4 reads nanoseconds [15:0], address 5 reads nanoseconds [31:16], address 6 reads seconds [15:0] and address 7 reads seconds [31:16].
- R4: Address 8 reads the 16-bit sequence identifier exactly as it was presented, with no byte swap.
- R5: Address 9 reads the message type in bits [15:12] and the direction in bit 11 (1 = transmit), with all other bits 0.
- R6: Writing address 1 with bit 0 set freezes the oldest entry, provided the queue is not empty. A later write with bit 1 set removes the frozen entry. A write with bit 1 set when no entry is frozen removes nothing.
- R7: Status bit 1 and the `irq_pending` output are 1 exactly while at least one entry is stored. Both become 1 in the cycle after the accepting edge.
- R8: The queue holds DEPTH entries (default 4) and returns them in arrival order.
- R9: An enabled event that arrives while the queue is full is dropped, and status bit 2 (overflow) is set. The overflow flag stays set until software writes address 2 with bit 2 set.
- R10: An accepted event and the removal of the frozen entry in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_sec | input | 32 | Current time of day, seconds |
| time_nsec | input | 32 | Current time of day, nanoseconds |
| evt_valid | input | 1 | One-cycle start-of-packet strobe for an event message |
| evt_seq | input | 16 | Sequence identifier of the event message |
| evt_type | input | 4 | Message type of the event message |
| evt_tx | input | 1 | Direction of the event, 1 = transmit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| irq_pending | output | 1 | High while the queue holds at least one entry |

## Verification
The queue state shows up at the ports within one cycle of any event. A wrong occupancy count makes `irq_pending` stay high or drop out of step with the reads, or makes the fifth capture land when it should have been dropped. A wrong read or write pointer returns another entry's sequence number or slice on the next read, so checking every field of every drained entry in order catches it. A freeze flag that is stuck or that clears too early shows as a removal that should not happen, or one that fails to happen. The bench sees this on `irq_pending` in the cycle after the end write.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] nsec;
    logic [15:0] seq;
    logic [3:0]  mtype;
    logic        dir_tx;
  } ts_entry_t;

  localparam int ENTRY_W  = $bits(ts_entry_t);
  localparam int REG_AW   = 4;
  localparam int REG_DW   = 16;

  localparam logic [REG_AW-1:0] A_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] A_RDCTL  = 4'd1;
  localparam logic [REG_AW-1:0] A_STATUS = 4'd2;
  localparam logic [REG_AW-1:0] A_W0     = 4'd4;
  localparam logic [REG_AW-1:0] A_W1     = 4'd5;
  localparam logic [REG_AW-1:0] A_W2     = 4'd6;
  localparam logic [REG_AW-1:0] A_W3     = 4'd7;
  localparam logic [REG_AW-1:0] A_SEQ    = 4'd8;
  localparam logic [REG_AW-1:0] A_INFO   = 4'd9;

  // Time slice: 0/1 = nanoseconds low/high, 2/3 = seconds low/high.
  function automatic logic [REG_DW-1:0] time_slice(ts_entry_t e, logic [1:0] idx);
    case (idx)
      2'd0:    return e.nsec[15:0];
      2'd1:    return e.nsec[31:16];
      2'd2:    return e.sec[15:0];
      default: return e.sec[31:16];
    endcase
  endfunction

  // Metadata word: type in [15:12], direction in bit 11.
  function automatic logic [REG_DW-1:0] info_word(ts_entry_t e);
    return {e.mtype, e.dir_tx, 11'd0};
  endfunction

endpackage

// File: rtl/ts_event_gate.sv
module ts_event_gate (
  input  logic sync_en,
  input  logic tx_en,
  input  logic rx_en,
  input  logic evt_valid,
  input  logic evt_tx,
  output logic accept
);
  logic dir_en;
  assign dir_en = evt_tx ? tx_en : rx_en;
  assign accept = evt_valid && sync_en && dir_en;
endmodule

// File: rtl/ts_entry_fifo.sv
module ts_entry_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 85
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] next_ptr(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign head    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
  a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && pop && !empty) |=> $stable(count));
endmodule

// File: rtl/ts_read_ctl.sv
module ts_read_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_start,
  input  logic wr_end,
  input  logic empty,
  output logic frozen,
  output logic pop
);
  assign pop = wr_end && frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   frozen <= 1'b0;
    else if (pop)                 frozen <= 1'b0;
    else if (wr_start && !empty)  frozen <= 1'b1;
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_end) |=> frozen);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && wr_end) |=> !frozen);
endmodule

// File: rtl/ts_capture_queue.sv
module ts_capture_queue
  import ts_cap_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] time_sec,
  input  logic [31:0] time_nsec,
  input  logic        evt_valid,
  input  logic [15:0] evt_seq,
  input  logic [3:0]  evt_type,
  input  logic        evt_tx,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_pending
);
  logic        sync_en, tx_en, rx_en, overflow;
  logic        accept, drop, empty, full, frozen, pop;
  logic        wr_start, wr_end, ovf_clear;
  ts_entry_t   new_entry, head_entry;
  logic [ENTRY_W-1:0] head_bits;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata[15:3];
  assign wr_start  = reg_wr && (reg_addr == A_RDCTL) && reg_wdata[0];
  assign wr_end    = reg_wr && (reg_addr == A_RDCTL) && reg_wdata[1];
  assign ovf_clear = reg_wr && (reg_addr == A_STATUS) && reg_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rx_en, tx_en, sync_en} <= 3'b000;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      {rx_en, tx_en, sync_en} <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (drop)      overflow <= 1'b1;
    else if (ovf_clear) overflow <= 1'b0;
  end

  ts_event_gate u_gate (
    .sync_en  (sync_en),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .evt_valid(evt_valid),
    .evt_tx   (evt_tx),
    .accept   (accept)
  );

  assign new_entry = '{sec: time_sec, nsec: time_nsec, seq: evt_seq,
                       mtype: evt_type, dir_tx: evt_tx};

  ts_entry_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (accept),
    .pop  (pop),
    .wdata(new_entry),
    .head (head_bits),
    .empty(empty),
    .full (full),
    .drop (drop)
  );

  assign head_entry = empty ? '0 : ts_entry_t'(head_bits);

  ts_read_ctl u_rdctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_start(wr_start),
    .wr_end  (wr_end),
    .empty   (empty),
    .frozen  (frozen),
    .pop     (pop)
  );

  assign irq_pending = !empty;

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = {13'd0, rx_en, tx_en, sync_en};
      A_STATUS: reg_rdata = {13'd0, overflow, irq_pending, 1'b0};
      A_W0:     reg_rdata = time_slice(head_entry, 2'd0);
      A_W1:     reg_rdata = time_slice(head_entry, 2'd1);
      A_W2:     reg_rdata = time_slice(head_entry, 2'd2);
      A_W3:     reg_rdata = time_slice(head_entry, 2'd3);
      A_SEQ:    reg_rdata = head_entry.seq;
      A_INFO:   reg_rdata = info_word(head_entry);
      default:  reg_rdata = '0;
    endcase
  end

  a_r7_irq_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> irq_pending);
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clear) |=> overflow);
  a_r2_ignored_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !sync_en && !pop) |=> $stable(irq_pending));
  a_r6_frozen_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> irq_pending);
endmodule

// File: tb/ts_capture_queue_test.sv
module ts_capture_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] time_sec = '0, time_nsec = '0;
  logic        evt_valid = 1'b0, evt_tx = 1'b0;
  logic [15:0] evt_seq = '0;
  logic [3:0]  evt_type = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_pending;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ts_capture_queue uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_sec(int i);
    return 32'hA5000000 ^ (i * 32'h00010203);
  endfunction
  function automatic logic [31:0] mk_ns(int i);
    return 32'h1234_0000 + i * 32'h0003_0111;
  endfunction

  task automatic evt(input int i, input logic [3:0] ty, input logic tx);
    evt_valid = 1'b1; evt_seq = 16'hC000 + 16'(i * 7); evt_type = ty; evt_tx = tx;
    time_sec = mk_sec(i); time_nsec = mk_ns(i);
    @(posedge clk); #1;
    evt_valid = 1'b0;
  endtask

  task automatic drain(input int i, input logic [3:0] ty, input logic tx);
    logic [15:0] d;
    wr(4'd1, 16'h0001);
    rd(4'd4, d); chk("R3 nsec lo", d, mk_ns(i) & 32'hFFFF);
    rd(4'd5, d); chk("R3 nsec hi", d, mk_ns(i) >> 16);
    rd(4'd6, d); chk("R3 sec lo", d, mk_sec(i) & 32'hFFFF);
    rd(4'd7, d); chk("R3 sec hi", d, mk_sec(i) >> 16);
    rd(4'd8, d); chk("R4 seq", d, 16'hC000 + 16'(i * 7));
    rd(4'd9, d); chk("R5 info", d, {ty, tx, 11'd0});
    wr(4'd1, 16'h0002);
    wr(4'd1, 16'h0000);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 irq", irq_pending, 0);
    rd(4'd0, d); chk("R1 ctrl", d, 0);
    rd(4'd2, d); chk("R1 status", d, 0);
    for (int a = 4; a <= 9; a++) begin
      rd(4'(a), d); chk("R1 empty entry", d, 0);
    end
    // R2 / R7: all enable combinations, both directions
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int dir = 0; dir < 2; dir++) begin
        bit expc;
        expc = cfg[0] && (dir == 1 ? cfg[1] : cfg[2]);
        wr(4'd0, 16'(cfg));
        evt(cfg * 2 + dir, 4'(cfg + dir), dir[0]);
        chk("R2 capture gating", irq_pending, expc);
        rd(4'd2, d); chk("R7 status pending", d, {13'd0, 1'b0, expc, 1'b0});
        if (expc) drain(cfg * 2 + dir, 4'(cfg + dir), dir[0]);
        chk("R7 pending after drain", irq_pending, 0);
      end
    end
    // R8 order + R5 all message types
    wr(4'd0, 16'h0007);
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) evt(100 + r * 4 + k, 4'(r * 4 + k), k[0]);
      rd(4'd2, d); chk("R8 full no overflow", d, 16'h0002);
      for (int k = 0; k < 4; k++) begin
        chk("R8 pending while stored", irq_pending, 1);
        drain(100 + r * 4 + k, 4'(r * 4 + k), k[0]);
      end
      chk("R8 empty after four", irq_pending, 0);
    end
    // R9 overflow
    for (int k = 0; k < 6; k++) evt(200 + k, 4'(k), 1'b1);
    rd(4'd2, d); chk("R9 overflow set", d, 16'h0006);
    for (int k = 0; k < 4; k++) drain(200 + k, 4'(k), 1'b1);
    chk("R9 drops not stored", irq_pending, 0);
    rd(4'd2, d); chk("R9 overflow sticky", d, 16'h0004);
    wr(4'd2, 16'h0004);
    rd(4'd2, d); chk("R9 overflow cleared", d, 16'h0000);
    // R6: end without start does nothing
    evt(300, 4'h3, 1'b0);
    wr(4'd1, 16'h0002); wr(4'd1, 16'h0000);
    chk("R6 end without freeze", irq_pending, 1);
    drain(300, 4'h3, 1'b0);
    // R6: start on empty queue does not freeze
    wr(4'd1, 16'h0001);
    evt(301, 4'h4, 1'b1);
    wr(4'd1, 16'h0002); wr(4'd1, 16'h0000);
    chk("R6 start on empty", irq_pending, 1);
    drain(301, 4'h4, 1'b1);
    // R10: pop and capture in the same cycle
    evt(400, 4'h1, 1'b0);
    wr(4'd1, 16'h0001);
    evt_valid = 1'b1; evt_seq = 16'hC000 + 16'(401 * 7); evt_type = 4'h2; evt_tx = 1'b1;
    time_sec = mk_sec(401); time_nsec = mk_ns(401);
    wr(4'd1, 16'h0002);
    evt_valid = 1'b0;
    chk("R10 one entry left", irq_pending, 1);
    wr(4'd1, 16'h0000);
    drain(401, 4'h2, 1'b1);
    chk("R10 empty at end", irq_pending, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule